// File: doc/BRIEF.md
# Periodic Two-Channel Sampling Sequencer

This block paces slow parameter refreshes. Two counters in a row divide the system clock. The first stage counts `PRE_DIV` cycles and the second counts `OVF_DIV` of those strobes, which gives one overflow event. A countdown register starts at `RELOAD`. Each overflow lowers it by one. When the last overflow of a window arrives, the countdown reloads at once and a sampling sequence is launched.

A sequence drives an external analog converter through a start/done handshake. The block powers the converter up and settles the channel select on channel 0. It then pulses start and waits for done, and captures the result. It repeats the same steps on channel 1. After the second capture it powers the converter down and raises a ready flag, which stays up until the consumer acknowledges it. While the converter is powered, the block also produces a clock-enable strobe for it at the system clock divided by `CONV_DIV`.

Top module: `sample_sched`

## Requirements
- R1: After reset is released, the first channel-0 start pulse is seen in cycle `RELOAD*PRE_DIV*OVF_DIV + 2`, counting the first clock edge with reset low as cycle 1.
- R2: Later channel-0 start pulses follow each other at an exact interval of `RELOAD*PRE_DIV*OVF_DIV` cycles, because the countdown reloads in the same cycle that it expires.
- R3: `conv_start` is high for exactly one cycle, only while `conv_en` is high. `conv_chan` has held its value for at least one cycle before the pulse.
- R4: In every sequence the first start uses channel 0 (`conv_chan`=0). The second start uses channel 1 (`conv_chan`=1), and it comes only after the done pulse that answers the first start.
- R5: The `conv_data` value that arrives with the done pulse answering the channel-0 start is stored in `res_ch0`. The value answering the channel-1 start is stored in `res_ch1`. Each register keeps its value until the next sequence overwrites it.
- R6: On the clock edge that captures the channel-1 result, `conv_en` goes low and `ready` goes high.
- R7: `ready` stays high until a one-cycle `ack`, and it is low in the cycle after the `ack`. If a sequence completes in the same cycle as an `ack`, the set wins.
- R8: A done pulse that arrives while no conversion is outstanding changes neither result register.
- R9: `conv_clk_en` is low whenever `conv_en` is low. Its first pulse comes `CONV_DIV-1` cycles after `conv_en` rises. Later pulses follow every `CONV_DIV` cycles while `conv_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse from the converter: the result is valid |
| conv_data | input | 10 | Converter result, valid together with `conv_done` |
| ack | input | 1 | One-cycle pulse from the consumer that clears `ready` |
| conv_start | output | 1 | One-cycle request for a conversion |
| conv_chan | output | 1 | Channel select: 0 or 1 |
| conv_en | output | 1 | Converter power enable, high for the length of a sequence |
| conv_clk_en | output | 1 | Converter clock-enable strobe |
| res_ch0 | output | 10 | Last captured channel-0 result |
| res_ch1 | output | 10 | Last captured channel-1 result |
| ready | output | 1 | Both results of a sequence are available |

## Verification
The assertions check the handshake shape on every cycle. These include the single-cycle start with the enable high and the channel select settled, the silence of the clock-enable strobe while the converter is off, and the hold and clear of `ready`. They also check that the result registers move only on a done pulse, and that `ready` is set in the same cycle that the enable drops. Other properties need a counted history and a model of the converter, so only the bench's scenarios can show them. These are the absolute launch cycle and the exact repeat interval, the channel order across a full sequence, the captured values, the strobe spacing, and the rejection of a stray done pulse while idle.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int RES_W = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET0,
        ST_GO0,
        ST_WAIT0,
        ST_SET1,
        ST_GO1,
        ST_WAIT1
    } seq_state_t;

    typedef struct packed {
        logic [RES_W-1:0] ch1;
        logic [RES_W-1:0] ch0;
    } result_pair_t;

    function automatic logic is_go(input seq_state_t s);
        return (s == ST_GO0) || (s == ST_GO1);
    endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic pulse
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign pulse = en && !clr && (cnt == LAST);
endmodule

// File: rtl/reload_cnt.sv
module reload_cnt #(
    parameter int RELOAD = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic fire
);
    localparam int W = (RELOAD > 1) ? $clog2(RELOAD + 1) : 1;
    localparam logic [W-1:0] INIT = W'(RELOAD);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= INIT;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (step) begin
                if (remain <= 1) begin
                    remain <= INIT;
                    fire   <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             done,
    input  logic [RES_W-1:0] data,
    input  logic             ack,
    output logic             start,
    output logic             chan,
    output logic             en,
    output result_pair_t     res,
    output logic             ready
);
    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            chan  <= 1'b0;
            en    <= 1'b0;
            res   <= '0;
            ready <= 1'b0;
        end else begin
            if (ack)
                ready <= 1'b0;
            unique case (state)
                ST_IDLE: if (trig) begin
                    state <= ST_SET0;
                    chan  <= 1'b0;
                    en    <= 1'b1;
                end
                ST_SET0: state <= ST_GO0;
                ST_GO0:  state <= ST_WAIT0;
                ST_WAIT0: if (done) begin
                    res.ch0 <= data;
                    chan    <= 1'b1;
                    state   <= ST_SET1;
                end
                ST_SET1: state <= ST_GO1;
                ST_GO1:  state <= ST_WAIT1;
                ST_WAIT1: if (done) begin
                    res.ch1 <= data;
                    en      <= 1'b0;
                    ready   <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign start = is_go(state);
endmodule

// File: rtl/sample_sched.sv
module sample_sched
    import sched_pkg::*;
#(
    parameter int PRE_DIV  = 1024,
    parameter int OVF_DIV  = 256,
    parameter int RELOAD   = 30,
    parameter int CONV_DIV = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             ack,
    output logic             conv_start,
    output logic             conv_chan,
    output logic             conv_en,
    output logic             conv_clk_en,
    output logic [RES_W-1:0] res_ch0,
    output logic [RES_W-1:0] res_ch1,
    output logic             ready
);
    localparam int NSTAGE = 2;

    logic [NSTAGE-1:0] stage_en;
    logic [NSTAGE-1:0] stage_pulse;
    logic              trig;
    result_pair_t      res;

    assign stage_en = {stage_pulse[0], 1'b1};

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        tick_div #(.DIV(g == 0 ? PRE_DIV : OVF_DIV)) u_div (
            .clk   (clk),
            .rst   (rst),
            .clr   (1'b0),
            .en    (stage_en[g]),
            .pulse (stage_pulse[g])
        );
    end

    reload_cnt #(.RELOAD(RELOAD)) u_reload (
        .clk  (clk),
        .rst  (rst),
        .step (stage_pulse[NSTAGE-1]),
        .fire (trig)
    );

    conv_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig),
        .done  (conv_done),
        .data  (conv_data),
        .ack   (ack),
        .start (conv_start),
        .chan  (conv_chan),
        .en    (conv_en),
        .res   (res),
        .ready (ready)
    );

    tick_div #(.DIV(CONV_DIV)) u_conv_clk (
        .clk   (clk),
        .rst   (rst),
        .clr   (!conv_en),
        .en    (conv_en),
        .pulse (conv_clk_en)
    );

    assign res_ch0 = res.ch0;
    assign res_ch1 = res.ch1;
endmodule

// File: rtl/sample_sched_chk.sv
module sample_sched_chk
    import sched_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             conv_done,
    input logic             ack,
    input logic             conv_start,
    input logic             conv_chan,
    input logic             conv_en,
    input logic             conv_clk_en,
    input logic [RES_W-1:0] res_ch0,
    input logic [RES_W-1:0] res_ch1,
    input logic             ready
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R3
    AST_START_POWERED: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> conv_en); // R3
    AST_CHAN_SETTLED: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $stable(conv_chan)); // R3
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> ($stable(res_ch0) && $stable(res_ch1))); // R5
    AST_READY_ON_POWERDOWN: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_en) |-> ready); // R6
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready && !ack) |=> ready); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!ready || $fell(conv_en))); // R7
    AST_CLKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !conv_en |-> !conv_clk_en); // R9
endmodule

bind sample_sched sample_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_done   (conv_done),
    .ack         (ack),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_en     (conv_en),
    .conv_clk_en (conv_clk_en),
    .res_ch0     (res_ch0),
    .res_ch1     (res_ch1),
    .ready       (ready)
);

// File: tb/tb_sample_sched.sv
module tb_sample_sched;
    localparam int PRE  = 4;
    localparam int OVF  = 4;
    localparam int REL  = 3;
    localparam int CDIV = 4;
    localparam int PER  = PRE * OVF * REL;
    localparam int NSEQ = 6;
    localparam int LAT  = 3;
    localparam int WDOG = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       ack = 1'b0;
    logic       conv_start, conv_chan, conv_en, conv_clk_en, ready;
    logic [9:0] res_ch0, res_ch1;

    sample_sched #(.PRE_DIV(PRE), .OVF_DIV(OVF), .RELOAD(REL), .CONV_DIV(CDIV)) dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data), .ack(ack),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_en(conv_en),
        .conv_clk_en(conv_clk_en), .res_ch0(res_ch0), .res_ch1(res_ch1), .ready(ready)
    );

    always #4 clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

    int n_chk = 0;
    int n_bad = 0;
    int mseq  = 0;
    logic [19:0] sb_q[$];
    logic [9:0]  last0, last1;
    bit          have_last = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model and driver: answers starts and pushes expected pairs
    initial begin
        logic [9:0] d0, d1;
        wait (!rst);
        for (int seq = 0; seq < NSEQ; seq++) begin
            do @(negedge clk); while (!conv_start);
            check(conv_chan == 1'b0, "R4 first channel", int'(conv_chan), 0);
            check(conv_en, "R3 enable at start", int'(conv_en), 1);
            if (seq == 0) check(ecnt == PER + 2, "R1 first launch", ecnt, PER + 2);
            else check(ecnt == PER + 2 + seq * PER, "R2 interval", ecnt, PER + 2 + seq * PER);
            if (have_last) begin
                check(res_ch0 == last0, "R8 res_ch0 kept", int'(res_ch0), int'(last0));
                check(res_ch1 == last1, "R8 res_ch1 kept", int'(res_ch1), int'(last1));
            end
            d0 = (seq == 0) ? 10'h3FF : 10'(seq * 97 + 5);
            d1 = (seq == 1) ? 10'h000 : 10'(1023 - seq * 61);
            @(negedge clk);
            check(!conv_start, "R3 single pulse", int'(conv_start), 0);
            repeat (LAT - 1) @(negedge clk);
            check(!conv_start, "R4 no early second start", int'(conv_start), 0);
            conv_data = d0; conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0; conv_data = 10'h2AA;
            do @(negedge clk); while (!conv_start);
            check(conv_chan == 1'b1, "R4 second channel", int'(conv_chan), 1);
            repeat (LAT) @(negedge clk);
            sb_q.push_back({d1, d0});
            conv_data = d1; conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0; conv_data = 10'h2AA;
            last0 = d0; last1 = d1; have_last = 1;
            if (seq == 2) begin
                repeat (4) @(negedge clk);
                conv_data = 10'h155; conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // monitor: pops expected pairs when the converter is powered down
    initial begin
        logic [19:0] exp;
        bit p_en = 0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (p_en && !conv_en) begin
                if (sb_q.size() == 0) begin
                    check(0, "R5 unexpected completion", 1, 0);
                end else begin
                    exp = sb_q.pop_front();
                    check(res_ch0 == exp[9:0], "R5 res_ch0", int'(res_ch0), int'(exp[9:0]));
                    check(res_ch1 == exp[19:10], "R5 res_ch1", int'(res_ch1), int'(exp[19:10]));
                end
                check(ready, "R6 ready at powerdown", int'(ready), 1);
                if (mseq == 3) begin
                    repeat (8) @(negedge clk);
                    check(ready, "R7 hold without ack", int'(ready), 1);
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                check(!ready, "R7 cleared by ack", int'(ready), 0);
                mseq++;
            end
            p_en = conv_en;
        end
    end

    // clock-enable strobe monitor
    initial begin
        int rise_c = -1;
        int last_c = -1;
        bit p_en = 0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (conv_en && !p_en) begin
                rise_c = ecnt;
                last_c = -1;
            end
            if (conv_clk_en === 1'b1) begin
                if (!conv_en) check(0, "R9 strobe while off", 1, 0);
                else if (last_c < 0) check(ecnt - rise_c == CDIV - 1, "R9 first strobe", ecnt - rise_c, CDIV - 1);
                else check(ecnt - last_c == CDIV, "R9 strobe spacing", ecnt - last_c, CDIV);
                last_c = ecnt;
            end
            p_en = conv_en;
        end
    end

    initial begin
        int waited = 0;
        repeat (3) @(negedge clk);
        check(!conv_start, "R3 reset start", int'(conv_start), 0);
        check(!conv_en, "R6 reset enable", int'(conv_en), 0);
        check(!ready, "R7 reset ready", int'(ready), 0);
        check(!conv_clk_en, "R9 reset strobe", int'(conv_clk_en), 0);
        check(res_ch0 == 10'd0 && res_ch1 == 10'd0, "R5 reset results", int'(res_ch0) + int'(res_ch1), 0);
        rst = 1'b0;
        while (mseq < NSEQ && waited < WDOG) begin
            @(negedge clk);
            waited++;
        end
        if (mseq < NSEQ) check(0, "watchdog expired", mseq, NSEQ);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule